// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block produces the 16x oversampling enable strobe for a 16550-style UART core. It runs from a 20 MHz reference clock and has three stages in series. The first is an integer pre-divider. Its ratio is picked by a 3-bit code. The second is a phase-accumulator rate multiplier, which keeps a fraction x/y of the pre-divided ticks. The third is a 16-bit divisor counter, which turns the remaining ticks into the sample strobe. Because the pre-divider ratios include values that are not powers of two, and because the multiplier is fractional, common baud rates come out almost exactly from a 20 MHz reference.

A word-addressed register port programs the three stages. The divisor bytes can be reached only while the line-control latch-enable input is high. A high-speed input doubles the effective multiplier, so a given baud rate needs half the x value. The pins carry no data stream, so every port is a plain control or status signal with no handshake.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, the pre-divider code is 4. The x/y register reads 0x0000FDE8, which is x = 0 and y = 65000. The divisor is 1. `sample_stb` is low.
- R2: The registers are 32 bits wide and are selected by word index:
  - index 0: divisor low byte, in bits 7:0
  - index 1: divisor high byte, in bits 7:0
  - index 10: pre-divider code, in bits 2:0
  - index 11: x/y register, with x in bits 31:16 and y in bits 15:0

  `reg_rdata` shows the selected register combinationally. An unmapped index reads 0.
- R3: While `dlab` is low, a write to index 0 or 1 is ignored, and a read of index 0 or 1 returns 0. While `dlab` is high, both bytes can be read and written.
- R4: The pre-divider codes 0 to 7 select the ratios 1, 2, 4, 8, 10, 12, 16 and 20, in that order.
- R5: On each pre-divided tick, the accumulator adds the effective x. When the sum is at least y, the accumulator subtracts y and emits one tick. When y = 0, no tick is emitted.
- R6: The strobe rate equals f_clk / ratio × x_eff / y / divisor. For example, 115200 baud needs a strobe rate of 1843200 per second. With code 4, y = 65000, x = 59904 and divisor 1, the generator yields 921 or 922 strobes in 10000 cycles.
- R7: While `hs_mode` is high, the effective x is 2x, capped at y. Otherwise the effective x is x.
- R8: A divisor of 0 acts as 65536.
- R9: An accepted write to any rate register clears the pre-divider counter, the accumulator and the divisor counter. For example, take code 1, x = 32500, y = 65000 and divisor 1, with the x/y write taken at clock edge E0. The first strobes then appear after edges E5, E9 and E13, and no strobe appears before E5. With code 0, x = y, effective x capped at y and divisor 0, the first strobe appears after edge E65537.
- R10: `sample_stb` is high for exactly one cycle and is never high in two consecutive cycles. A requested rate above f_clk/2 saturates at f_clk/2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| dlab | input | 1 | Divisor latch access enable |
| hs_mode | input | 1 | High-speed (double rate) mode |
| sample_stb | output | 1 | 16x oversampling strobe |

## Verification
Some rules are checked by the assertions on every cycle:
- the strobe is never high in two consecutive cycles;
- the pre-divider count stays below its ratio;
- the accumulator stays below y;
- a fractional tick follows only a pre-divided tick;
- the divisor and the code do not change without an accepted write.

Other behaviour can be shown only by the bench's scenarios:
- the rate formula itself, in normal and high-speed mode and over random configurations;
- the exact cycle of the first strobe after a clearing write;
- the wrap of a zero divisor to 65536;
- saturation at half the clock rate.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int REG_W    = 32;
  localparam int ADR_W    = 4;
  localparam int FRAC_W   = 16;
  localparam int DIV_W    = 16;
  localparam int CODE_W   = 3;
  localparam int RATIO_W  = 5;

  localparam logic [ADR_W-1:0] IDX_DIV_LO = 4'd0;
  localparam logic [ADR_W-1:0] IDX_DIV_HI = 4'd1;
  localparam logic [ADR_W-1:0] IDX_PRE    = 4'd10;
  localparam logic [ADR_W-1:0] IDX_FRAC   = 4'd11;

  localparam logic [CODE_W-1:0] PRE_RST  = 3'd4;
  localparam logic [FRAC_W-1:0] Y_RST    = 16'd65000;
  localparam logic [DIV_W-1:0]  DIV_RST  = 16'd1;

  function automatic logic [RATIO_W-1:0] pre_ratio(input logic [CODE_W-1:0] code);
    case (code)
      3'd0: pre_ratio = 5'd1;
      3'd1: pre_ratio = 5'd2;
      3'd2: pre_ratio = 5'd4;
      3'd3: pre_ratio = 5'd8;
      3'd4: pre_ratio = 5'd10;
      3'd5: pre_ratio = 5'd12;
      3'd6: pre_ratio = 5'd16;
      default: pre_ratio = 5'd20;
    endcase
  endfunction
endpackage

// File: rtl/baud_regs.sv
module baud_regs
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADR_W-1:0]  addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              dlab,
  output logic [REG_W-1:0]  rdata,
  output logic [DIV_W-1:0]  divisor,
  output logic [CODE_W-1:0] code,
  output logic [FRAC_W-1:0] x_val,
  output logic [FRAC_W-1:0] y_val,
  output logic              clr
);
  logic wr_lo, wr_hi, wr_pre, wr_frac;

  assign wr_lo   = wr && dlab && (addr == IDX_DIV_LO);
  assign wr_hi   = wr && dlab && (addr == IDX_DIV_HI);
  assign wr_pre  = wr && (addr == IDX_PRE);
  assign wr_frac = wr && (addr == IDX_FRAC);
  assign clr     = wr_lo | wr_hi | wr_pre | wr_frac;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      divisor <= DIV_RST;
      code    <= PRE_RST;
      x_val   <= '0;
      y_val   <= Y_RST;
    end else begin
      if (wr_lo)   divisor[7:0]  <= wdata[7:0];
      if (wr_hi)   divisor[15:8] <= wdata[7:0];
      if (wr_pre)  code          <= wdata[CODE_W-1:0];
      if (wr_frac) begin
        x_val <= wdata[2*FRAC_W-1:FRAC_W];
        y_val <= wdata[FRAC_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      IDX_DIV_LO: if (dlab) rdata[7:0] = divisor[7:0];
      IDX_DIV_HI: if (dlab) rdata[7:0] = divisor[15:8];
      IDX_PRE:    rdata[CODE_W-1:0] = code;
      IDX_FRAC:   rdata = {x_val, y_val};
      default:    rdata = '0;
    endcase
  end

  // R3: a divisor write without latch access leaves the divisor unchanged
  a_r3_div_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !dlab) |=> $stable(divisor));
  // R2: the pre-divider code changes only through its own index
  a_r2_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == IDX_PRE) |=> $stable(code));
endmodule

// File: rtl/baud_prediv.sv
module baud_prediv
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  logic [RATIO_W-1:0] ratio;
  logic [RATIO_W-1:0] cnt;

  assign ratio = pre_ratio(code);
  assign tick  = (cnt == ratio - 5'd1);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 5'd1;
  end

  // R4: the count stays inside the selected ratio
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < ratio);
endmodule

// File: rtl/baud_frac.sv
module baud_frac
  import baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hs,
  input  logic [FRAC_W-1:0] x_val,
  input  logic [FRAC_W-1:0] y_val,
  input  logic              tick_in,
  output logic              tick_out
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc;
  logic [SUM_W-1:0]  x_dbl, x_eff, y_ext, sum;
  logic              hit;

  assign y_ext = {1'b0, y_val};
  assign x_dbl = hs ? {x_val, 1'b0} : {1'b0, x_val};
  assign x_eff = (x_dbl > y_ext) ? y_ext : x_dbl;
  assign sum   = {1'b0, acc} + x_eff;
  assign hit   = (y_val != '0) && (sum >= y_ext);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      acc      <= '0;
      tick_out <= 1'b0;
    end else begin
      tick_out <= tick_in && hit;
      if (tick_in && (y_val != '0))
        acc <= hit ? FRAC_W'(sum - y_ext) : sum[FRAC_W-1:0];
    end
  end

  // R5: the accumulator never reaches y
  a_r5_acc_below_y: assert property (@(posedge clk) disable iff (!rst_n)
    (y_val != '0) |-> (acc < y_val));
  // R5: an output tick needs an input tick in the cycle before
  a_r5_tick_source: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_in |=> !tick_out);
endmodule

// File: rtl/baud_divcnt.sv
module baud_divcnt
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [DIV_W-1:0] divisor,
  input  logic             tick,
  output logic             stb
);
  logic [DIV_W-1:0] cnt, last;
  logic             req, owe;

  assign last = divisor - 1'b1;  // 0 wraps to 65535, i.e. divide by 65536
  assign req  = tick && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
      stb <= 1'b0;
      owe <= 1'b0;
    end else begin
      if (tick) cnt <= req ? '0 : cnt + 1'b1;
      stb <= (req | owe) & ~stb;
      owe <= (req | owe) & stb;
    end
  end

  // R10: never two strobes in a row
  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  // R8: the count never passes the terminal value
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(divisor) |-> (cnt <= last));
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dlab,
  input  logic        hs_mode,
  output logic        sample_stb
);
  logic [DIV_W-1:0]  divisor;
  logic [CODE_W-1:0] code;
  logic [FRAC_W-1:0] x_val, y_val;
  logic              clr, pre_tick, frac_tick;

  baud_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dlab(dlab), .rdata(reg_rdata), .divisor(divisor), .code(code),
    .x_val(x_val), .y_val(y_val), .clr(clr)
  );

  baud_prediv u_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .code(code), .tick(pre_tick)
  );

  baud_frac u_frac (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hs(hs_mode), .x_val(x_val),
    .y_val(y_val), .tick_in(pre_tick), .tick_out(frac_tick)
  );

  baud_divcnt u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .divisor(divisor), .tick(frac_tick),
    .stb(sample_stb)
  );
endmodule

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dlab = 1'b0;
  logic        hs_mode = 1'b0;
  logic        sample_stb;

  int n_checks = 0;
  int n_errors = 0;
  int adjacent = 0;
  logic prev_stb = 1'b0;

  frac_baud_gen uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dlab(dlab),
    .hs_mode(hs_mode), .sample_stb(sample_stb)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && prev_stb && sample_stb) adjacent++;
    prev_stb <= sample_stb;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ratio_of(input int code);
    case (code)
      0: return 1;  1: return 2;  2: return 4;  3: return 8;
      4: return 10; 5: return 12; 6: return 16; default: return 20;
    endcase
  endfunction

  function automatic longint model_count(input int code, input longint x, input longint y,
                                         input longint dv, input bit hs, input longint n);
    longint xe, pre, fr, d, s;
    if (y == 0) return 0;
    xe  = hs ? 2 * x : x;
    if (xe > y) xe = y;
    pre = n / ratio_of(code);
    fr  = pre * xe / y;
    d   = (dv == 0) ? 65536 : dv;
    s   = fr / d;
    if (s > n / 2) s = n / 2;
    return s;
  endfunction

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic configure(input int code, input int x, input int y, input int dv, input bit hs);
    hs_mode = hs;
    dlab = 1'b1;
    wr_reg(4'd0, 32'(dv & 255));
    wr_reg(4'd1, 32'((dv >> 8) & 255));
    dlab = 1'b0;
    wr_reg(4'd10, 32'(code));
    wr_reg(4'd11, {16'(x), 16'(y)});
  endtask

  task automatic count_window(input int n, output longint c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sample_stb) c++;
    end
  endtask

  task automatic rate_check(input string req, input int code, input int x, input int y,
                            input int dv, input bit hs, input int n);
    longint c, e, diff;
    configure(code, x, y, dv, hs);
    count_window(n, c);
    e = model_count(code, x, y, dv, hs, n);
    diff = c - e;
    check(diff >= -2 && diff <= 2, req, c, e);
  endtask

  initial begin
    #(190000 * 20);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    longint c;
    int hits;
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset defaults
    check(sample_stb == 1'b0, "R1 stb low", sample_stb, 0);
    rd_reg(4'd10, d); check(d == 32'd4, "R1 pre code", d, 4);
    rd_reg(4'd11, d); check(d == 32'h0000FDE8, "R1 x/y", d, 32'hFDE8);
    dlab = 1'b1;
    rd_reg(4'd0, d); check(d == 32'd1, "R1 div lo", d, 1);
    rd_reg(4'd1, d); check(d == 32'd0, "R1 div hi", d, 0);
    rd_reg(4'd5, d); check(d == 32'd0, "R2 unmapped", d, 0);

    // R3 latch gating
    dlab = 1'b0;
    wr_reg(4'd0, 32'h55);
    rd_reg(4'd0, d); check(d == 32'd0, "R3 read gated", d, 0);
    dlab = 1'b1;
    rd_reg(4'd0, d); check(d == 32'd1, "R3 write ignored", d, 1);
    wr_reg(4'd1, 32'hA7);
    rd_reg(4'd1, d); check(d == 32'hA7, "R3 write accepted", d, 32'hA7);
    dlab = 1'b0;

    // R2 field positions
    wr_reg(4'd11, 32'h1234ABCD);
    rd_reg(4'd11, d); check(d == 32'h1234ABCD, "R2 x/y fields", d, 32'h1234ABCD);

    // R6 115200 baud, R7 high-speed uses half x
    rate_check("R6 115200 normal", 4, 59904, 65000, 1, 1'b0, 10000);
    rate_check("R7 115200 hs", 4, 29952, 65000, 1, 1'b1, 10000);

    // R9 clear on write, exact first strobe
    configure(1, 32500, 65000, 1, 1'b0);
    hits = 0;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk);
      if (sample_stb != (k == 5 || k == 9 || k == 13)) hits++;
    end
    check(hits == 0, "R9 strobe phase after clear", hits, 0);

    // R10 saturation at half rate
    rate_check("R10 saturation", 0, 64999, 65000, 1, 1'b1, 1000);

    // R5 y = 0 holds off
    rate_check("R5 y zero", 0, 100, 0, 1, 1'b0, 500);

    // R4 each pre-divider code, R5 random fractions
    for (int i = 0; i < 6; i++) begin
      int y, x, dv, code;
      code = (i < 2) ? 7 - i : int'($urandom % 8);
      y    = 1000 + int'($urandom % 64535);
      x    = int'($urandom % y);
      dv   = 2 + int'($urandom % 7);
      rate_check(i < 2 ? "R4 code ratio" : "R5 random config", code, x, y, dv, 1'($urandom % 2), 4000);
    end

    // R8 divisor 0 = 65536, first strobe after E65537
    configure(0, 65000, 65000, 0, 1'b0);
    hits = 0;
    for (int k = 1; k <= 65540; k++) begin
      @(negedge clk);
      if (sample_stb && k != 65537) hits++;
      if (!sample_stb && k == 65537) hits++;
    end
    check(hits == 0, "R8 zero divisor period", hits, 0);

    check(adjacent == 0, "R10 no adjacent strobes", adjacent, 0);
    c = 0;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule